// File: doc/BRIEF.md
# Timestamped Link Delay Queue

This block stands in for one link of a simulated on-chip network inside a hardware network simulator. Flit or credit descriptors enter in order and are held in a small first-in, first-out store. Each descriptor is stamped with the cycle at which it may leave. That cycle is the simulated time at arrival plus a programmable latency, kept modulo 1024. A single global simulated-time counter is shared by every node, and it paces all movement through the block.

The head descriptor is offered at the output only once global time has reached its stamp. The number of descriptors released during one simulated cycle is capped by a programmable bandwidth. The latency and the bandwidth are loaded serially through a configuration shift chain, which can be daisy-chained with other nodes. Many fabric clock cycles may pass within a single simulated cycle, so the queue can release several descriptors per simulated cycle, up to the cap.

Top module: `link_delay_queue`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the latency field is 0 and the bandwidth field is 1. cfg_dout is therefore 0.
- R2: A descriptor accepted while sim_time is T gets the ready stamp (T + latency) mod 1024. It is not offered at the output before sim_time equals that stamp. Latency must be below 512.
- R3: The head is due when (sim_time - stamp) mod 1024 is below 512. This keeps release correct when the stamp or sim_time wraps past 1023.
- R4: While sim_time holds one value, at most `bandwidth` descriptors are dequeued. The count restarts whenever sim_time changes value. A bandwidth of 0 keeps out_valid low.
- R5: Descriptors leave in exactly the order they were accepted.
- R6: in_ready is low exactly when DEPTH descriptors are held. An input offered while in_ready is low is dropped, and no stored entry is overwritten.
- R7: On each clock with cfg_shift_en high, the chain shifts left by one bit and takes cfg_din in at bit 0. cfg_dout is bit 13. Bits 13..4 are the latency and bits 3..0 are the bandwidth. Both fields take effect as soon as they are held. With cfg_shift_en low, the chain holds its value.
- R8: out_valid is high only when the head is due and within the bandwidth cap, and out_desc then shows the head descriptor. A descriptor is removed only on a clock with out_valid and out_ready both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sim_time | input | 10 | Global simulated time |
| in_valid | input | 1 | Descriptor offered at input |
| in_ready | output | 1 | Queue can accept a descriptor |
| in_desc | input | 36 | Incoming descriptor |
| out_valid | output | 1 | Head descriptor is released |
| out_ready | input | 1 | Consumer takes the released descriptor |
| out_desc | output | 36 | Head descriptor |
| cfg_shift_en | input | 1 | Shift the configuration chain |
| cfg_din | input | 1 | Serial configuration input |
| cfg_dout | output | 1 | Serial configuration output to next node |

## Verification
The hardest case to reach from the ports is a stamp that wraps past 1023 while descriptors are still queued. A naive comparison would release such a descriptor at once. The bench drives sim_time to 1020 with a latency of 10 and checks that nothing leaves until time 6 after the wrap. It also fills the queue with the output stalled, reprograms the chain with a non-empty queue to a bandwidth of 0, and holds sim_time fixed over many fabric clocks so that the per-cycle cap is reached. A behavioural queue model predicts every output on every clock.

// File: rtl/link_dq_pkg.sv
// Shared constants and types for the timestamped link delay queue.
// Assumes the timestamp width is fixed at 10 bits across the simulator.
package link_dq_pkg;
    localparam int TS_W  = 10;
    localparam int BW_W  = 4;
    localparam int CFG_W = TS_W + BW_W;

    typedef logic [TS_W-1:0] stamp_t;

    // Decoded configuration fields held in the shift chain
    typedef struct packed {
        stamp_t          latency;
        logic [BW_W-1:0] bandwidth;
    } link_cfg_t;
endpackage

// File: rtl/link_cfg_chain.sv
// Serial configuration register for one link node.
// Shifts left by one bit per enabled clock, with cfg_din entering at bit 0.
// The fields are decoded straight from the register, so new values apply at once.
// Assumes the upstream driver sends the latency MSB first, then the bandwidth MSB first.
module link_cfg_chain
    import link_dq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      shift_en,
    input  logic      din,
    output logic      dout,
    output link_cfg_t cfg
);
    logic [CFG_W-1:0] chain_q;

    // Shift register: load the reset defaults, otherwise shift when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= {{TS_W{1'b0}}, BW_W'(1)};
        else if (shift_en)
            chain_q <= {chain_q[CFG_W-2:0], din};
    end

    // Field decode and serial output
    always_comb begin
        cfg  = link_cfg_t'(chain_q);
        dout = chain_q[CFG_W-1];
    end

    assert_chain_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain_q));
endmodule

// File: rtl/stamp_fifo.sv
// First-in, first-out store of descriptors paired with their ready stamps.
// The head entry is presented combinationally from the storage array.
// Assumes push is never asserted while full (the top gates it with in_ready).
module stamp_fifo
    import link_dq_pkg::*;
#(
    parameter int DESC_W = 36,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DESC_W-1:0] push_desc,
    input  stamp_t            push_stamp,
    input  logic              pop,
    output logic [DESC_W-1:0] head_desc,
    output stamp_t            head_stamp,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DESC_W-1:0] desc_mem  [DEPTH];
    stamp_t            stamp_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  fill;

    // Storage write: only the addressed slot changes, on an accepted push
    always_ff @(posedge clk) begin
        if (push) begin
            desc_mem[wr_ptr]  <= push_desc;
            stamp_mem[wr_ptr] <= push_stamp;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // Head presentation and occupancy flags
    always_comb begin
        head_desc  = desc_mem[rd_ptr];
        head_stamp = stamp_mem[rd_ptr];
        empty      = (fill == '0);
        full       = (fill == CNT_W'(DEPTH));
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop && !empty) |=> ($stable(head_desc) && $stable(head_stamp)));
endmodule

// File: rtl/release_gate.sv
// Decides whether the queue head may leave in this fabric cycle.
// The head is due once the modular age (now - stamp) has its top bit clear.
// A release counter limits dequeues per simulated cycle and restarts on a time change.
// Assumes latency stays below half the stamp range.
module release_gate
    import link_dq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  stamp_t          now,
    input  stamp_t          head_stamp,
    input  logic            head_present,
    input  logic [BW_W-1:0] bw_limit,
    input  logic            take,
    output logic            release_ok,
    output logic            pop
);
    stamp_t          last_now;
    logic [BW_W-1:0] sent_q;
    logic [BW_W-1:0] sent_eff;
    stamp_t          age;

    // Release decision from the stamp age and the bandwidth used so far
    always_comb begin
        sent_eff   = (now != last_now) ? '0 : sent_q;
        age        = now - head_stamp;
        release_ok = head_present && !age[TS_W-1] && (sent_eff < bw_limit);
        pop        = release_ok && take;
    end

    // Track the last seen time and the releases made within it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_now <= '0;
            sent_q   <= '0;
        end else begin
            last_now <= now;
            sent_q   <= sent_eff + BW_W'(pop);
        end
    end
endmodule

// File: rtl/link_delay_queue.sv
// One simulated network link: a descriptor queue whose head leaves only when
// global simulated time reaches the stamp, and at most `bandwidth` times per
// simulated cycle. Latency and bandwidth come from a serial configuration chain.
// Assumes sim_time advances monotonically modulo 1024 and latency < 512.
module link_delay_queue
    import link_dq_pkg::*;
#(
    parameter int DESC_W = 36,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   sim_time,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DESC_W-1:0] in_desc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DESC_W-1:0] out_desc,
    input  logic              cfg_shift_en,
    input  logic              cfg_din,
    output logic              cfg_dout
);
    link_cfg_t cfg;
    logic      push, pop, empty, full;
    stamp_t    head_stamp;
    stamp_t    due_stamp;

    link_cfg_chain u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (cfg_shift_en),
        .din      (cfg_din),
        .dout     (cfg_dout),
        .cfg      (cfg)
    );

    // Accept when space remains; stamp with arrival time plus latency
    always_comb begin
        in_ready  = !full;
        push      = in_valid && !full;
        due_stamp = sim_time + cfg.latency;
    end

    stamp_fifo #(.DESC_W(DESC_W), .DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_desc  (in_desc),
        .push_stamp (due_stamp),
        .pop        (pop),
        .head_desc  (out_desc),
        .head_stamp (head_stamp),
        .empty      (empty),
        .full       (full)
    );

    release_gate u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .now          (sim_time),
        .head_stamp   (head_stamp),
        .head_present (!empty),
        .bw_limit     (cfg.bandwidth),
        .take         (out_ready),
        .release_ok   (out_valid),
        .pop          (pop)
    );

    assert_valid_needs_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !empty);
    assert_full_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !in_ready);
    assert_zero_bw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.bandwidth == '0) |-> !out_valid);
endmodule

// File: tb/test_link_delay_queue.sv
module test_link_delay_queue;
    localparam int DW    = 36;
    localparam int DEPTH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [9:0]    sim_time = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_desc = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_desc;
    logic          cfg_shift_en = 1'b0;
    logic          cfg_din = 1'b0;
    logic          cfg_dout;

    always #2 clk = ~clk;

    link_delay_queue #(.DESC_W(DW), .DEPTH(DEPTH)) i_link_delay_queue (
        .clk(clk), .rst_n(rst_n), .sim_time(sim_time),
        .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
        .out_valid(out_valid), .out_ready(out_ready), .out_desc(out_desc),
        .cfg_shift_en(cfg_shift_en), .cfg_din(cfg_din), .cfg_dout(cfg_dout)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state
    logic [DW-1:0] q_desc[$];
    int            q_stamp[$];
    logic [13:0]   m_chain;
    int            m_sent, m_last;
    int            out_count;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One fabric clock: predict, compare, then advance the model at the edge
    task automatic step(input bit v, input logic [DW-1:0] d, input bit r, input bit sh, input bit sd);
        int lat, bw, eff, age;
        bit ev, acc, deq;
        in_valid = v; in_desc = d; out_ready = r; cfg_shift_en = sh; cfg_din = sd;
        #1;
        lat = int'(m_chain[13:4]);
        bw  = int'(m_chain[3:0]);
        eff = (int'(sim_time) != m_last) ? 0 : m_sent;
        ev  = 0;
        if (q_desc.size() > 0) begin
            age = (int'(sim_time) - q_stamp[0] + 1024) % 1024;
            ev  = (age < 512) && (eff < bw);
        end
        check("R2/R3/R4 out_valid", 64'(out_valid), 64'(ev));
        if (ev) check("R5/R8 out_desc", 64'(out_desc), 64'(q_desc[0]));
        check("R6 in_ready", 64'(in_ready), 64'(q_desc.size() < DEPTH));
        check("R7 cfg_dout", 64'(cfg_dout), 64'(m_chain[13]));
        acc = v && (q_desc.size() < DEPTH);
        deq = ev && r;
        @(posedge clk);
        if (deq) begin void'(q_desc.pop_front()); void'(q_stamp.pop_front()); out_count++; end
        if (acc) begin q_desc.push_back(d); q_stamp.push_back((int'(sim_time) + lat) % 1024); end
        m_sent = eff + int'(deq);
        m_last = int'(sim_time);
        if (sh) m_chain = {m_chain[12:0], sd};
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) step(0, '0, r, 0, 0);
    endtask

    task automatic load_cfg(input int lat, input int bw);
        logic [13:0] w;
        w = {10'(lat), 4'(bw)};
        for (int i = 13; i >= 0; i--) step(0, '0, 0, 1, w[i]);
    endtask

    // Advance simulated time, spending `per` fabric clocks at each value
    task automatic run_time(input int ticks, input int per, input bit r);
        for (int t = 0; t < ticks; t++) begin
            idle(per, r);
            sim_time = sim_time + 10'd1;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_chain = {10'd0, 4'd1}; m_sent = 0; m_last = 0; out_count = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state seen while reset is held
        check("R1 out_valid", 64'(out_valid), 64'd0);
        check("R1 in_ready", 64'(in_ready), 64'd1);
        check("R1 cfg_dout", 64'(cfg_dout), 64'd0);
        rst_n = 1'b1;
        idle(2, 1);

        // R2/R5: latency 3, bandwidth 1, three arrivals at one time
        load_cfg(3, 1);
        sim_time = 10'd100;
        step(1, 36'hA01, 1, 0, 0);
        step(1, 36'hA02, 1, 0, 0);
        step(1, 36'hA03, 1, 0, 0);
        run_time(8, 3, 1);
        check("R2 all released", 64'(out_count), 64'd3);

        // R4: bandwidth 2, five arrivals, time held for many clocks
        load_cfg(2, 2);
        sim_time = 10'd200;
        for (int i = 0; i < 5; i++) step(1, 36'hB00 + 36'(i), 1, 0, 0);
        run_time(6, 6, 1);

        // R6: fill with the output stalled, extra inputs must be dropped
        load_cfg(1, 3);
        sim_time = 10'd300;
        for (int i = 0; i < DEPTH + 3; i++) step(1, 36'hC00 + 36'(i), 0, 0, 0);
        check("R6 full", 64'(in_ready), 64'd0);
        sim_time = 10'd302;
        idle(4, 0);
        run_time(5, 5, 1);
        check("R6 drained", 64'(in_ready), 64'd1);

        // R4: bandwidth 0 reprogrammed with a queued descriptor
        load_cfg(0, 1);
        step(1, 36'hD01, 0, 0, 0);
        load_cfg(0, 0);
        run_time(3, 4, 1);
        load_cfg(0, 1);
        run_time(2, 3, 1);

        // R3: stamp wraps past 1023
        load_cfg(10, 2);
        sim_time = 10'd1020;
        step(1, 36'hE01, 1, 0, 0);
        step(1, 36'hE02, 1, 0, 0);
        run_time(12, 3, 1);

        // R8: latency 0 with toggling out_ready
        load_cfg(0, 3);
        for (int i = 0; i < 12; i++) step(i % 3 != 2, 36'hF00 + 36'(i), i % 2 == 0, 0, 0);
        run_time(4, 4, 1);
        check("R8 queue empty", 64'(out_valid), 64'd0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule